// File: doc/BRIEF.md
# Lockable Program-Timing Prescaler Register

This block holds a single byte-wide control register that sets how far the system bus clock is divided, and a free-running prescaler that turns that setting into a one-cycle tick enable. Program and erase timing in the memory controller counts these ticks. Software should choose the divider so that the tick comes at about 1 MHz. The tick period is the field value plus one bus-clock cycles.

The register contains three fields. Bit 7 is a read-only flag that shows whether the register has taken a write since reset. Bit 6 is a lock. Bits 5:0 hold the divider. The mode input selects normal or special mode. In normal mode the lock can only be set, and once set it freezes the divider until reset. In special mode every writable bit can be changed at any time. A busy input from the command sequencer blocks all register updates while a memory command is running.

Top module: `prog_tick_divider`

## Requirements
- R1: After reset every register bit reads 0 and the prescaler count is zero. With a divider of 0, `tickEn` is high on every cycle after reset.
- R2: Bit 7 ignores the written data. It reads 1 after the first accepted write since reset and 0 before it. Any accepted write sets it, including a write whose divider bits are blocked by the lock.
- R3: In normal mode (`specialMode`=0), writing 1 to bit 6 sets the lock. Writing 0 to bit 6 never clears it. Only reset clears it.
- R4: In normal mode, while bit 6 reads 1, an accepted write leaves bits 5:0 unchanged. If the lock is still 0 when a write arrives, that write updates bits 5:0 even when it also sets bit 6.
- R5: In special mode (`specialMode`=1), an accepted write copies data bits 6:0 into the register as they are. The lock can be cleared, and it does not block the divider.
- R6: A write presented while `cmdBusy`=1 is dropped entirely. Bits 7:0 and the prescaler count keep their values.
- R7: With divider value D, `tickEn` is high for exactly one cycle out of every D+1 bus cycles.
- R8: An accepted write that updates bits 5:0 restarts the count at zero on the next cycle. The first tick with the new value D then appears D cycles after the write edge.
- R9: A write happens only on a cycle where both `regSel`=1 and `wrEn`=1. Otherwise the register and the count are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode, 0 = normal mode |
| cmdBusy | input | 1 | Memory command in progress; blocks writes |
| regSel | input | 1 | Register select from the bus decoder |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value {loaded, lock, divider} |
| tickEn | output | 1 | One-cycle timing tick enable |

## Verification
Two things can happen on the same edge: an accepted write that changes the divider, and the prescaler reaching its terminal count. The bench provokes this collision with directed writes placed on a tick cycle and with random write strobes issued while ticks run at small divider values. It then checks that the count restarts from zero and does not wrap, and that the next tick comes after exactly the new period. A second collision is a write that sets the lock and changes the divider in the same cycle. It is judged against a model in which the lock state before the write decides whether the divider is blocked.

// File: rtl/prog_tick_pkg.sv
package prog_tick_pkg;

  typedef struct packed {
    logic accept;
    logic wrDiv;
    logic lockNext;
    logic restart;
  } ctrlStrobes_t;

endpackage

// File: rtl/prog_tick_ctrl.sv
module prog_tick_ctrl
  import prog_tick_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         specialMode,
  input  logic         cmdBusy,
  input  logic         regSel,
  input  logic         wrEn,
  input  logic         wrLockBit,
  input  logic         curLock,
  output ctrlStrobes_t strobes
);

  logic accepted;
  logic divOpen;

  assign accepted = regSel && wrEn && !cmdBusy;
  assign divOpen  = specialMode || !curLock;

  always_comb begin
    strobes.accept   = accepted;
    strobes.wrDiv    = accepted && divOpen;
    strobes.restart  = accepted && divOpen;
    if (!accepted)        strobes.lockNext = curLock;
    else if (specialMode) strobes.lockNext = wrLockBit;
    else                  strobes.lockNext = curLock | wrLockBit;
  end

  p_busy_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |-> !strobes.accept && !strobes.wrDiv);

  p_select_needed_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && wrEn) |-> !strobes.accept);

endmodule

// File: rtl/prog_tick_dp.sv
module prog_tick_dp
  import prog_tick_pkg::*;
#(
  parameter int DivW = 6,
  localparam int RegW = DivW + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            specialMode,
  input  ctrlStrobes_t    strobes,
  input  logic [DivW-1:0] wrDiv,
  output logic            lockOut,
  output logic [RegW-1:0] regValue,
  output logic            tickEn
);

  logic            loadedQ;
  logic            lockQ;
  logic [DivW-1:0] divQ;
  logic [DivW-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ <= 1'b0;
      lockQ   <= 1'b0;
      divQ    <= '0;
    end else begin
      if (strobes.accept) loadedQ <= 1'b1;
      lockQ <= strobes.lockNext;
      if (strobes.wrDiv) divQ <= wrDiv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.restart) cntQ <= '0;
    else if (cntQ >= divQ)    cntQ <= '0;
    else                      cntQ <= cntQ + 1'b1;
  end

  assign tickEn   = (cntQ == divQ);
  assign lockOut  = lockQ;
  assign regValue = {loadedQ, lockQ, divQ};

  p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadedQ |=> loadedQ);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !specialMode) |=> lockQ);

  p_div_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !specialMode) |=> $stable(divQ));

  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= divQ);

  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && divQ != '0 && !strobes.restart) |=> !tickEn);

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> cntQ == '0);

endmodule

// File: rtl/prog_tick_divider.sv
module prog_tick_divider
  import prog_tick_pkg::*;
#(
  parameter int DivW = 6,
  localparam int RegW = DivW + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            specialMode,
  input  logic            cmdBusy,
  input  logic            regSel,
  input  logic            wrEn,
  input  logic [RegW-1:0] wrData,
  output logic [RegW-1:0] rdData,
  output logic            tickEn
);

  ctrlStrobes_t strobes;
  logic         curLock;
  logic [RegW-1:0] regValue;
  logic         unusedTop;

  assign unusedTop = wrData[RegW-1];

  prog_tick_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .specialMode(specialMode),
    .cmdBusy    (cmdBusy),
    .regSel     (regSel),
    .wrEn       (wrEn),
    .wrLockBit  (wrData[RegW-2]),
    .curLock    (curLock),
    .strobes    (strobes)
  );

  prog_tick_dp #(.DivW(DivW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .specialMode(specialMode),
    .strobes    (strobes),
    .wrDiv      (wrData[DivW-1:0]),
    .lockOut    (curLock),
    .regValue   (regValue),
    .tickEn     (tickEn)
  );

  assign rdData = regValue;

  p_bit7_ignores_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && wrEn && !cmdBusy && !unusedTop) |=> rdData[RegW-1]);

  p_busy_holds_reg_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |=> $stable(rdData));

endmodule

// File: tb/tb_prog_tick_divider.sv
`timescale 1ns/1ps
module tb_prog_tick_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic       cmdBusy = 1'b0;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       tickEn;

  always #2 clk = ~clk;

  prog_tick_divider dut (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .cmdBusy(cmdBusy),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .tickEn(tickEn)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic       mLoaded, mLock;
  logic [5:0] mDiv, mCnt;

  function automatic logic expTick(input logic [5:0] c, input logic [5:0] d);
    return c == d;
  endfunction

  task automatic modelReset();
    mLoaded = 0; mLock = 0; mDiv = 0; mCnt = 0;
  endtask

  task automatic modelEdge(input logic sel, input logic we, input logic [7:0] d,
                           input logic busy, input logic spc);
    logic acc, divOk;
    logic [5:0] nextCnt;
    acc = sel && we && !busy;
    divOk = spc || !mLock;
    nextCnt = (mCnt >= mDiv) ? 6'd0 : mCnt + 6'd1;
    if (acc) begin
      mLoaded = 1'b1;
      if (divOk) begin mDiv = d[5:0]; nextCnt = 6'd0; end
      mLock = spc ? d[6] : (mLock | d[6]);
    end
    mCnt = nextCnt;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string extra);
    check({"R2 loaded ", extra}, {7'd0, rdData[7]}, {7'd0, mLoaded});
    check({"R3 R5 lock ", extra}, {7'd0, rdData[6]}, {7'd0, mLock});
    check({"R4 R5 divider ", extra}, {2'd0, rdData[5:0]}, {2'd0, mDiv});
    check({"R7 R8 tick ", extra}, {7'd0, tickEn}, {7'd0, expTick(mCnt, mDiv)});
  endtask

  task automatic step(input logic sel, input logic we, input logic [7:0] d,
                      input logic busy, input logic spc, input string tag);
    regSel = sel; wrEn = we; wrData = d; cmdBusy = busy; specialMode = spc;
    @(posedge clk);
    modelEdge(sel, we, d, busy, spc);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regSel = 0; wrEn = 0; cmdBusy = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1 reset");
    check("R1 reset value", rdData, 8'h00);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    doReset();
    for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 0, 0, "R1 idle tick");
    step(1, 1, 8'h85, 0, 0, "R2 bit7 ignored");
    for (int i = 0; i < 8; i++) step(0, 0, 8'h00, 0, 0, "R7 period 6");
    step(1, 1, 8'h43, 1, 0, "R6 busy drop");
    step(1, 0, 8'h43, 0, 0, "R9 no strobe");
    step(0, 1, 8'h43, 0, 0, "R9 no select");
    step(1, 1, 8'h44, 0, 0, "R4 lock and div together");
    step(1, 1, 8'h01, 0, 0, "R3 R4 locked write");
    check("R3 lock kept", rdData, 8'hC4);
    for (int i = 0; i < 12; i++) step(0, 0, 8'h00, 0, 0, "R7 period 5");
    step(1, 1, 8'h02, 0, 1, "R5 special clears lock");
    check("R5 special value", rdData, 8'h82);
    step(1, 1, 8'h40, 0, 1, "R5 special relock");
    step(1, 1, 8'h41, 0, 1, "R5 special div under lock");
    for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 0, 1, "R8 restart");
    doReset();
    check("R2 loaded clear after reset", {7'd0, rdData[7]}, 8'h00);
    for (int n = 0; n < 4000; n++) begin
      logic spc, sel, we, busy;
      logic [7:0] d;
      if (n % 900 == 899) doReset();
      spc  = ($urandom % 5) == 0;
      sel  = ($urandom % 3) != 0;
      we   = ($urandom % 4) == 0;
      busy = ($urandom % 4) == 0;
      d    = 8'($urandom);
      if (($urandom % 6) != 0) d[6] = 1'b0;
      if (($urandom % 3) != 0) d[5:3] = 3'd0;
      step(sel, we, d, busy, spc, "random");
    end
    summary();
  end

endmodule